// File: doc/BRIEF.md
# Three-Class Interrupt Entry and Return Controller

This block decides, every cycle, whether a processor core takes an interrupt. If it takes one, the block also decides which interrupt and what state it saves. Each interrupt belongs to one of three classes: noncritical, critical or machine check. Requests arrive as per-class level lines, split into asynchronous events (external, timer, error inputs) and synchronous causes raised by the instruction at the current program counter. The enable bits that gate them come from the core's machine state word.

On entry the block writes the resume address and the machine state word into a save/restore pair that belongs to the taken class alone. One cycle later it redirects fetch to that class's fixed vector. In the same cycle it hands the core an updated machine state word, with the enables for that class and every lower class cleared. Each class has its own return strobe, which restores the address and state from that class's own pair. Because each class has separate storage, a critical or machine-check entry can preempt a running noncritical handler and leave its saved context untouched.

Top module: `trap_class_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, take_o is 0 and redir_vld_o is 0, even when enabled requests are present.
- R2: A machine-check request, asynchronous or synchronous, is taken only when the ME enable (machine state bit 3) is 1.
- R3: An asynchronous noncritical request is taken only when EE (bit 1) is 1. Synchronous noncritical and synchronous critical requests are never masked.
- R4: An asynchronous critical request is taken only when CE (bit 2) is 1.
- R5: Among eligible requests, machine check wins over critical, and critical wins over noncritical. Within one class, a synchronous request is taken ahead of an asynchronous one.
- R6: The saved address for an asynchronous entry is pc_nxt_i. For a synchronous entry it is pc_cur_i, or pc_nxt_i when sync_nxt_i for that class is 1. The saved state is the machine state word used for the mask check.
- R7: One cycle after an entry, take_o is one-hot (bit 0 noncritical, bit 1 critical, bit 2 machine check), redir_vld_o is 1 and redir_pc_o is the class vector (defaults 0x0500, 0x0100, 0x0200). msr_upd_o is that state word with EE cleared, with CE also cleared for critical and machine check, and with ME also cleared for machine check. All other bits are kept.
- R8: One cycle after ret_i[c] (bit order as take_o; the highest set bit counts) with no request taken, redir_vld_o is 1, take_o is 0, and redir_pc_o and msr_upd_o are the address and state saved by the last entry of class c.
- R9: An entry of one class never changes the pair of another class.
- R10: When a return strobe and a request arrive in the same cycle, the mask check uses the restored state. An entry taken in that cycle saves the restored address and the restored state, and its outputs follow R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_async_i | input | 3 | Asynchronous request per class |
| req_sync_i | input | 3 | Synchronous request per class |
| sync_nxt_i | input | 3 | Per class: synchronous entry saves the next address |
| pc_cur_i | input | AW | Address of the current instruction |
| pc_nxt_i | input | AW | Address of the next instruction |
| msr_i | input | MW | Current machine state word |
| ret_i | input | 3 | Return strobe per class |
| take_o | output | 3 | One-hot class taken, one cycle after acceptance |
| redir_vld_o | output | 1 | Fetch redirect and state update valid |
| redir_pc_o | output | AW | Fetch redirect address |
| msr_upd_o | output | MW | Machine state word to install |

## Verification
Two situations are hard to reach from the ports. In the first, a return and a new request land in the same cycle, so that the restored enables disagree with the live msr_i. In the second, a preempted lower-class pair must still hold its value after a higher class has entered and returned. The bench first builds a noncritical context with known address and state. It then drives a critical entry on top of it and unwinds both returns in order. Finally it issues return strobes together with requests while msr_i is set opposite to the saved enables. In one case the restored state allows the entry and in the other it masks it.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NCLS   = 3;
  localparam int CLS_NC = 0;
  localparam int CLS_CR = 1;
  localparam int CLS_MC = 2;

  typedef struct packed {
    logic       hit;
    logic [1:0] cls;
    logic       sync;
  } pick_t;
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int MW     = 8,
  parameter int EE_BIT = 1,
  parameter int CE_BIT = 2,
  parameter int ME_BIT = 3
) (
  input  logic [NCLS-1:0] req_async,
  input  logic [NCLS-1:0] req_sync,
  input  logic [MW-1:0]   msr,
  output pick_t           pick
);
  logic elig_mc, elig_cr, elig_nc;

  always_comb begin
    elig_mc = (req_async[CLS_MC] | req_sync[CLS_MC]) & msr[ME_BIT];
    elig_cr = req_sync[CLS_CR] | (req_async[CLS_CR] & msr[CE_BIT]);
    elig_nc = req_sync[CLS_NC] | (req_async[CLS_NC] & msr[EE_BIT]);
    pick = '0;
    if (elig_mc) begin
      pick.hit  = 1'b1;
      pick.cls  = 2'(CLS_MC);
      pick.sync = req_sync[CLS_MC];
    end else if (elig_cr) begin
      pick.hit  = 1'b1;
      pick.cls  = 2'(CLS_CR);
      pick.sync = req_sync[CLS_CR];
    end else if (elig_nc) begin
      pick.hit  = 1'b1;
      pick.cls  = 2'(CLS_NC);
      pick.sync = req_sync[CLS_NC];
    end
  end
endmodule

// File: rtl/trap_bank.sv
module trap_bank #(
  parameter int AW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] pc_d,
  input  logic [MW-1:0] msr_d,
  output logic [AW-1:0] pc_q,
  output logic [MW-1:0] msr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      msr_q <= '0;
    end else if (we) begin
      pc_q  <= pc_d;
      msr_q <= msr_d;
    end
  end
endmodule

// File: rtl/trap_class_ctrl.sv
module trap_class_ctrl
  import trap_pkg::*;
#(
  parameter int          AW     = 16,
  parameter int          MW     = 8,
  parameter int          EE_BIT = 1,
  parameter int          CE_BIT = 2,
  parameter int          ME_BIT = 3,
  parameter logic [AW-1:0] VEC_NC = 16'h0500,
  parameter logic [AW-1:0] VEC_CR = 16'h0100,
  parameter logic [AW-1:0] VEC_MC = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    req_async_i,
  input  logic [2:0]    req_sync_i,
  input  logic [2:0]    sync_nxt_i,
  input  logic [AW-1:0] pc_cur_i,
  input  logic [AW-1:0] pc_nxt_i,
  input  logic [MW-1:0] msr_i,
  input  logic [2:0]    ret_i,
  output logic [2:0]    take_o,
  output logic          redir_vld_o,
  output logic [AW-1:0] redir_pc_o,
  output logic [MW-1:0] msr_upd_o
);
  localparam logic [MW-1:0] M_EE = MW'(1) << EE_BIT;
  localparam logic [MW-1:0] M_CE = MW'(1) << CE_BIT;
  localparam logic [MW-1:0] M_ME = MW'(1) << ME_BIT;

  logic [AW-1:0] sv_pc  [NCLS];
  logic [MW-1:0] sv_msr [NCLS];
  logic [NCLS-1:0] bank_we;

  logic          ret_hit;
  logic [1:0]    ret_cls;
  logic [AW-1:0] rst_pc;
  logic [MW-1:0] rst_msr;
  logic [MW-1:0] eff_msr;
  pick_t         pick;
  logic [AW-1:0] save_pc;
  logic [MW-1:0] clr_mask;
  logic [AW-1:0] vec_pc;

  logic          vld_d;
  logic [2:0]    take_d;
  logic [AW-1:0] pc_d;
  logic [MW-1:0] msr_d;

  // return side: highest strobe wins
  always_comb begin
    ret_hit = |ret_i;
    if (ret_i[CLS_MC])      ret_cls = 2'(CLS_MC);
    else if (ret_i[CLS_CR]) ret_cls = 2'(CLS_CR);
    else                    ret_cls = 2'(CLS_NC);
    rst_pc  = sv_pc[ret_cls];
    rst_msr = sv_msr[ret_cls];
    eff_msr = ret_hit ? rst_msr : msr_i;
  end

  trap_select #(
    .MW(MW), .EE_BIT(EE_BIT), .CE_BIT(CE_BIT), .ME_BIT(ME_BIT)
  ) u_sel (
    .req_async (req_async_i),
    .req_sync  (req_sync_i),
    .msr       (eff_msr),
    .pick      (pick)
  );

  always_comb begin
    if (ret_hit)
      save_pc = rst_pc;
    else if (pick.sync && !sync_nxt_i[pick.cls])
      save_pc = pc_cur_i;
    else
      save_pc = pc_nxt_i;

    clr_mask = M_EE;
    vec_pc   = VEC_NC;
    case (pick.cls)
      2'(CLS_CR): begin
        clr_mask = M_EE | M_CE;
        vec_pc   = VEC_CR;
      end
      2'(CLS_MC): begin
        clr_mask = M_EE | M_CE | M_ME;
        vec_pc   = VEC_MC;
      end
      default: ;
    endcase
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_bank
    assign bank_we[c] = pick.hit && (pick.cls == 2'(c));
    trap_bank #(.AW(AW), .MW(MW)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bank_we[c]),
      .pc_d  (save_pc),
      .msr_d (eff_msr),
      .pc_q  (sv_pc[c]),
      .msr_q (sv_msr[c])
    );
  end

  // next-state
  always_comb begin
    vld_d  = pick.hit | ret_hit;
    take_d = pick.hit ? bank_we : 3'b000;
    pc_d   = pick.hit ? vec_pc : rst_pc;
    msr_d  = pick.hit ? (eff_msr & ~clr_mask) : rst_msr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_vld_o <= 1'b0;
      take_o      <= '0;
      redir_pc_o  <= '0;
      msr_upd_o   <= '0;
    end else begin
      redir_vld_o <= vld_d;
      take_o      <= take_d;
      if (vld_d) begin
        redir_pc_o <= pc_d;
        msr_upd_o  <= msr_d;
      end
    end
  end
endmodule

// File: rtl/trap_class_chk.sv
module trap_class_chk #(
  parameter int          AW     = 16,
  parameter int          MW     = 8,
  parameter int          EE_BIT = 1,
  parameter int          CE_BIT = 2,
  parameter int          ME_BIT = 3,
  parameter logic [AW-1:0] VEC_NC = 16'h0500,
  parameter logic [AW-1:0] VEC_CR = 16'h0100,
  parameter logic [AW-1:0] VEC_MC = 16'h0200
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    req_async_i,
  input logic [2:0]    req_sync_i,
  input logic [MW-1:0] msr_i,
  input logic [2:0]    ret_i,
  input logic [2:0]    take_o,
  input logic          redir_vld_o,
  input logic [AW-1:0] redir_pc_o,
  input logic [MW-1:0] msr_upd_o
);
  AST_MC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i == 3'b000 && !msr_i[ME_BIT]) |=> !take_o[2]); // R2
  AST_NC_ASYNC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i == 3'b000 && !req_sync_i[0] && !msr_i[EE_BIT]) |=> !take_o[0]); // R3
  AST_CR_ASYNC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i == 3'b000 && !req_sync_i[1] && !msr_i[CE_BIT]) |=> !take_o[1]); // R4
  AST_MC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i == 3'b000 && msr_i[ME_BIT] && (req_async_i[2] || req_sync_i[2])) |=> take_o[2]); // R5
  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_o)); // R7
  AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o != 3'b000) |-> (redir_vld_o &&
      redir_pc_o == (take_o[2] ? VEC_MC : take_o[1] ? VEC_CR : VEC_NC))); // R7
  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o != 3'b000) |-> (!msr_upd_o[EE_BIT] &&
      (take_o[0] || !msr_upd_o[CE_BIT]) && (!take_o[2] || !msr_upd_o[ME_BIT]))); // R7
  AST_RET_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i != 3'b000 && req_async_i == 3'b000 && req_sync_i == 3'b000)
      |=> (redir_vld_o && take_o == 3'b000)); // R8
endmodule

bind trap_class_ctrl trap_class_chk #(
  .AW(AW), .MW(MW), .EE_BIT(EE_BIT), .CE_BIT(CE_BIT), .ME_BIT(ME_BIT),
  .VEC_NC(VEC_NC), .VEC_CR(VEC_CR), .VEC_MC(VEC_MC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_async_i (req_async_i),
  .req_sync_i  (req_sync_i),
  .msr_i       (msr_i),
  .ret_i       (ret_i),
  .take_o      (take_o),
  .redir_vld_o (redir_vld_o),
  .redir_pc_o  (redir_pc_o),
  .msr_upd_o   (msr_upd_o)
);

// File: tb/test_trap_class_ctrl.sv
`timescale 1ns/1ps
module test_trap_class_ctrl;
  localparam int AW = 16;
  localparam int MW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    req_async_i, req_sync_i, sync_nxt_i, ret_i;
  logic [AW-1:0] pc_cur_i, pc_nxt_i;
  logic [MW-1:0] msr_i;
  logic [2:0]    take_o;
  logic          redir_vld_o;
  logic [AW-1:0] redir_pc_o;
  logic [MW-1:0] msr_upd_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  trap_class_ctrl i_trap_class_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_async_i(req_async_i), .req_sync_i(req_sync_i), .sync_nxt_i(sync_nxt_i),
    .pc_cur_i(pc_cur_i), .pc_nxt_i(pc_nxt_i), .msr_i(msr_i), .ret_i(ret_i),
    .take_o(take_o), .redir_vld_o(redir_vld_o), .redir_pc_o(redir_pc_o),
    .msr_upd_o(msr_upd_o)
  );

  // row: {async[2:0], sync[2:0], sync_nxt[2:0], msr[7:0], expected take[2:0]}
  localparam int NV = 16;
  localparam logic [19:0] TBL [NV] = '{
    {3'b001, 3'b000, 3'b000, 8'h02, 3'b001},
    {3'b001, 3'b000, 3'b000, 8'hF5, 3'b000},
    {3'b000, 3'b001, 3'b000, 8'h00, 3'b001},
    {3'b000, 3'b001, 3'b001, 8'h80, 3'b001},
    {3'b010, 3'b000, 3'b000, 8'h04, 3'b010},
    {3'b010, 3'b000, 3'b000, 8'hFB, 3'b000},
    {3'b100, 3'b000, 3'b000, 8'h08, 3'b100},
    {3'b100, 3'b000, 3'b000, 8'hF7, 3'b000},
    {3'b000, 3'b100, 3'b000, 8'h00, 3'b000},
    {3'b111, 3'b000, 3'b000, 8'h0E, 3'b100},
    {3'b011, 3'b000, 3'b000, 8'h06, 3'b010},
    {3'b001, 3'b001, 3'b000, 8'h02, 3'b001},
    {3'b110, 3'b000, 3'b000, 8'h0A, 3'b100},
    {3'b010, 3'b000, 3'b000, 8'h0A, 3'b000},
    {3'b000, 3'b010, 3'b001, 8'h00, 3'b010},
    {3'b000, 3'b111, 3'b000, 8'h08, 3'b100}
  };

  function automatic logic [AW-1:0] vec_of(input logic [2:0] t);
    return t[2] ? 16'h0200 : t[1] ? 16'h0100 : 16'h0500;
  endfunction

  function automatic logic [MW-1:0] clr_of(input logic [2:0] t);
    return t[2] ? 8'h0E : t[1] ? 8'h06 : 8'h02;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_async_i = '0; req_sync_i = '0; sync_nxt_i = '0; ret_i = '0;
  endtask

  // entry then matching return; checks outputs one cycle after each
  task automatic entry_and_return(input string tag, input logic [2:0] ra, input logic [2:0] rs,
                                  input logic [2:0] sn, input logic [MW-1:0] m,
                                  input logic [2:0] exp_t, input logic [AW-1:0] cur,
                                  input logic [AW-1:0] nxt);
    int c;
    logic [AW-1:0] exp_pc;
    @(negedge clk);
    req_async_i = ra; req_sync_i = rs; sync_nxt_i = sn; msr_i = m;
    pc_cur_i = cur; pc_nxt_i = nxt;
    @(negedge clk);
    idle();
    chk({tag, " take"}, 32'(take_o), 32'(exp_t));
    if (exp_t != 3'b000) begin
      c = exp_t[2] ? 2 : exp_t[1] ? 1 : 0;
      exp_pc = (rs[c] && !sn[c]) ? cur : nxt;
      chk("R7 redir_vld", 32'(redir_vld_o), 32'd1);
      chk("R7 vector", 32'(redir_pc_o), 32'(vec_of(exp_t)));
      chk("R7 msr cleared", 32'(msr_upd_o), 32'(m & ~clr_of(exp_t)));
      ret_i = exp_t;
      @(negedge clk);
      ret_i = '0;
      chk("R6 saved address", 32'(redir_pc_o), 32'(exp_pc));
      chk("R8 restored msr", 32'(msr_upd_o), 32'(m));
      chk("R8 no take on return", 32'(take_o), 32'd0);
    end else begin
      chk({tag, " no redirect"}, 32'(redir_vld_o), 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    msr_i = 8'h0E; pc_cur_i = 16'h0040; pc_nxt_i = 16'h0044;
    rst_n = 1'b0;
    req_async_i = 3'b111;
    repeat (3) @(negedge clk);
    chk("R1 take in reset", 32'(take_o), 32'd0);
    chk("R1 redir in reset", 32'(redir_vld_o), 32'd0);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 take after reset", 32'(take_o), 32'd0);
    chk("R1 redir after reset", 32'(redir_vld_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] e;
      e = TBL[i];
      entry_and_return("R2/R3/R4/R5 row", e[19:17], e[16:14], e[13:11], e[10:3], e[2:0],
                       16'(16'h1000 + i * 16), 16'(16'h1004 + i * 16));
    end

    // R9: critical preempts a noncritical handler; both pairs unwind intact
    @(negedge clk);
    req_async_i = 3'b001; msr_i = 8'h06; pc_cur_i = 16'h2000; pc_nxt_i = 16'h2004;
    @(negedge clk);
    idle();
    chk("R9 nc entry", 32'(take_o), 32'b001);
    req_async_i = 3'b010; msr_i = 8'h04; pc_cur_i = 16'h3004; pc_nxt_i = 16'h3008;
    @(negedge clk);
    idle();
    chk("R9 cr preempt take", 32'(take_o), 32'b010);
    chk("R9 cr preempt msr", 32'(msr_upd_o), 32'h00);
    ret_i = 3'b010;
    @(negedge clk);
    ret_i = 3'b001;
    chk("R9 cr return pc", 32'(redir_pc_o), 32'h3008);
    chk("R9 cr return msr", 32'(msr_upd_o), 32'h04);
    @(negedge clk);
    ret_i = '0;
    chk("R9 nc pair intact pc", 32'(redir_pc_o), 32'h2004);
    chk("R9 nc pair intact msr", 32'(msr_upd_o), 32'h06);

    // R10: return and request together, restored EE enables the entry
    ret_i = 3'b001; req_async_i = 3'b001; msr_i = 8'h00; pc_nxt_i = 16'h5555;
    @(negedge clk);
    idle();
    chk("R10 take on restored msr", 32'(take_o), 32'b001);
    chk("R10 vector", 32'(redir_pc_o), 32'h0500);
    chk("R10 msr from restored", 32'(msr_upd_o), 32'h04);
    ret_i = 3'b001;
    @(negedge clk);
    ret_i = '0;
    chk("R10 saved restored pc", 32'(redir_pc_o), 32'h2004);
    chk("R10 saved restored msr", 32'(msr_upd_o), 32'h06);

    // R10: restored state masks a request the live msr would allow
    req_sync_i = 3'b001; msr_i = 8'h04; pc_cur_i = 16'h6000; pc_nxt_i = 16'h6004;
    @(negedge clk);
    idle();
    chk("R3 sync nc with EE off", 32'(take_o), 32'b001);
    ret_i = 3'b001; req_async_i = 3'b001; msr_i = 8'h02;
    @(negedge clk);
    idle();
    chk("R10 masked by restored msr", 32'(take_o), 32'd0);
    chk("R10 return redirect", 32'(redir_pc_o), 32'h6000);
    chk("R10 return msr", 32'(msr_upd_o), 32'h04);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule